// File: doc/BRIEF.md
# Acquisition Event Latch Status Register

This block builds the 8-bit auxiliary status byte of a data-acquisition controller. Four bits are live copies of level inputs: FIFO empty, FIFO almost full, D/A buffer occupied and acquisition running. Three bits report sticky event latches: data lost, conversion event and timer overflow. The conversion-event bit is the OR of two separate latches, one for end-of-scan and one for the FIFO reaching almost full. The last bit is a pre-trigger flag. It is held from an external trigger until the stop command.

Software never clears a latch by reading the byte. A latch clears only when software writes a zero into its own bit of the auxiliary control register. A one in that bit leaves the latch alone. The same control register holds the pre-trigger enable. The timer's selected clock and the external trigger are asynchronous, so each passes through a synchronizer before edge detection. All other event inputs are synchronous to the system clock.

Top module: `acq_event_status`

## Requirements
- R1: status_o[0] equals fifo_empty_i and status_o[1] equals fifo_afull_i in every cycle (live, no latency).
- R2: status_o[5] equals da_busy_i and status_o[7] equals ad_run_i in every cycle (live, no latency).
- R3: A rising edge on data_lost_i sets status_o[2] after the next clock edge.
- R4: status_o[3] is the OR of an end-of-scan latch, set by a rising edge of eos_i, and an almost-full latch, set by a rising edge of fifo_afull_i. Each is set after the next clock edge and each is cleared independently.
- R5: status_o[4] sets when tmr_final_i is high at a rising edge of tmr_clk_i. With the default two synchronizer stages, the bit reads 1 after the third system clock edge following the input change. A timer clock edge with tmr_final_i low has no effect.
- R6: Once set, a latch holds through any number of cycles, through input changes and through control writes that carry 1 in its clear bit.
- R7: A control write with a 0 in bit 2 clears the data-lost latch, bit 3 the end-of-scan latch, bit 4 the almost-full latch and bit 5 the overflow latch. The latch reads 0 after the write's clock edge.
- R8: If a set event and a clearing write reach the same latch in the same cycle, the latch reads 1 afterwards.
- R9: Control bit 6 is the pre-trigger enable. After reset it is 0, and while it is 0, status_o[6] reads 0 and the held trigger state is discarded.
- R10: With pre-trigger enabled, status_o[6] reads 1 after the third clock edge following a rising edge of ext_trig_i. It holds until a rising edge of ad_stop_i, and reads 0 after the next edge. If a stop and a synchronized trigger arrive in the same cycle, the stop wins.
- R11: While rst_ni is low, all latches, the trigger flag and the pre-trigger enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_empty_i | input | 1 | A/D FIFO empty level |
| fifo_afull_i | input | 1 | A/D FIFO almost-full level |
| data_lost_i | input | 1 | Data-lost event, synchronous |
| eos_i | input | 1 | End-of-scan event, synchronous |
| tmr_final_i | input | 1 | Timer counter sits at its final count |
| tmr_clk_i | input | 1 | Selected timer clock, asynchronous |
| da_busy_i | input | 1 | D/A buffer register occupied |
| ext_trig_i | input | 1 | External trigger, asynchronous |
| ad_stop_i | input | 1 | A/D stop command, synchronous |
| ad_run_i | input | 1 | A/D running level |
| ctrl_we_i | input | 1 | Auxiliary control write strobe |
| ctrl_wdata_i | input | 8 | Auxiliary control write data |
| status_o | output | 8 | Auxiliary status byte |

## Verification
A latch that loses its state or fails to set shows on its status bit one clock edge after the event or write. For the overflow and trigger bits, the error shows three edges later because of the synchronizers. A clear bit decoded to the wrong position leaves one latch set and drops another, and this is visible at the next sample. The live bits have no storage, so a wiring fault shows in the same cycle in the input sweep. A trigger flag that keeps its state across a disable shows only after pre-trigger is enabled again.

// File: rtl/acq_status_pkg.sv
package acq_status_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned CTRL_W = 8;
  localparam int unsigned NUM_EVT = 4;

  // status bit positions
  localparam int unsigned ST_EMPTY  = 0;
  localparam int unsigned ST_AFULL  = 1;
  localparam int unsigned ST_LOST   = 2;
  localparam int unsigned ST_CONV   = 3;
  localparam int unsigned ST_OVF    = 4;
  localparam int unsigned ST_DA     = 5;
  localparam int unsigned ST_TRIG   = 6;
  localparam int unsigned ST_RUN    = 7;

  // control bit positions; clear bits contiguous in latch order
  localparam int unsigned CTL_CLR_LO  = 2;
  localparam int unsigned CTL_CLR_HI  = CTL_CLR_LO + NUM_EVT - 1;
  localparam int unsigned CTL_PRETRIG = 6;

  typedef enum logic [1:0] {
    EVT_LOST  = 2'd0,
    EVT_EOS   = 2'd1,
    EVT_AFULL = 2'd2,
    EVT_OVF   = 2'd3
  } evt_e;
endpackage

// File: rtl/acq_sync.sv
module acq_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (STAGES == 0) begin : g_pass
    assign q_o = d_i;
  end else begin : g_chain
    logic [STAGES-1:0][WIDTH-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '0;
      end else begin
        chain_q[0] <= d_i;
        for (int k = 1; k < int'(STAGES); k++) chain_q[k] <= chain_q[k-1];
      end
    end
    assign q_o = chain_q[STAGES-1];
  end
endmodule

// File: rtl/acq_rise_det.sv
module acq_rise_det #(
  parameter int unsigned STAGES = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_s, lvl_prev_q;

  acq_sync #(.WIDTH(1), .STAGES(STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lvl_i),
    .q_o   (lvl_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_prev_q <= 1'b0;
    else         lvl_prev_q <= lvl_s;
  end

  assign rise_o = lvl_s & ~lvl_prev_q;
endmodule

// File: rtl/acq_sticky.sv
module acq_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= set_i | (q_q & ~clr_i);
  end
  assign q_o = q_q;
endmodule

// File: rtl/acq_trig_flag.sv
module acq_trig_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic trig_i,
  input  logic stop_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (!en_i || stop_i) flag_d = 1'b0;
    else if (trig_i)     flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q & en_i;
endmodule

// File: rtl/acq_event_status.sv
module acq_event_status
  import acq_status_pkg::*;
#(
  parameter int unsigned TMR_SYNC  = 2,
  parameter int unsigned TRIG_SYNC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_empty_i,
  input  logic              fifo_afull_i,
  input  logic              data_lost_i,
  input  logic              eos_i,
  input  logic              tmr_final_i,
  input  logic              tmr_clk_i,
  input  logic              da_busy_i,
  input  logic              ext_trig_i,
  input  logic              ad_stop_i,
  input  logic              ad_run_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [STAT_W-1:0] status_o
);
  logic [NUM_EVT-1:0] ev_lvl, ev_rise, ev_set, ev_clr, ev_q;
  logic tmr_rise, trig_rise, stop_rise;
  logic pretrig_q, trig_flag;

  assign ev_lvl = {1'b0, fifo_afull_i, eos_i, data_lost_i};

  // synchronous event sources: plain edge detect
  for (genvar e = 0; e < int'(NUM_EVT) - 1; e++) begin : g_evt_det
    acq_rise_det #(.STAGES(0)) i_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (ev_lvl[e]),
      .rise_o(ev_rise[e])
    );
  end

  acq_rise_det #(.STAGES(TMR_SYNC)) i_tmr_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (tmr_clk_i),
    .rise_o(tmr_rise)
  );
  assign ev_rise[EVT_OVF] = tmr_rise & tmr_final_i;

  assign ev_set = ev_rise;
  assign ev_clr = {NUM_EVT{ctrl_we_i}} & ~ctrl_wdata_i[CTL_CLR_HI:CTL_CLR_LO];

  for (genvar e = 0; e < int'(NUM_EVT); e++) begin : g_latch
    acq_sticky i_latch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (ev_set[e]),
      .clr_i (ev_clr[e]),
      .q_o   (ev_q[e])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pretrig_q <= 1'b0;
    else if (ctrl_we_i) pretrig_q <= ctrl_wdata_i[CTL_PRETRIG];
  end

  acq_rise_det #(.STAGES(TRIG_SYNC)) i_trig_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (ext_trig_i),
    .rise_o(trig_rise)
  );

  acq_rise_det #(.STAGES(0)) i_stop_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (ad_stop_i),
    .rise_o(stop_rise)
  );

  acq_trig_flag i_trig (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (pretrig_q),
    .trig_i(trig_rise),
    .stop_i(stop_rise),
    .flag_o(trig_flag)
  );

  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl_wdata_i[CTRL_W-1], ctrl_wdata_i[CTL_CLR_LO-1:0], ev_lvl[EVT_OVF]};

  always_comb begin
    status_o           = '0;
    status_o[ST_EMPTY] = fifo_empty_i;
    status_o[ST_AFULL] = fifo_afull_i;
    status_o[ST_LOST]  = ev_q[EVT_LOST];
    status_o[ST_CONV]  = ev_q[EVT_EOS] | ev_q[EVT_AFULL];
    status_o[ST_OVF]   = ev_q[EVT_OVF];
    status_o[ST_DA]    = da_busy_i;
    status_o[ST_TRIG]  = trig_flag;
    status_o[ST_RUN]   = ad_run_i;
  end
endmodule

// File: rtl/acq_event_status_chk.sv
module acq_event_status_chk
  import acq_status_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_empty_i,
  input logic              fifo_afull_i,
  input logic              data_lost_i,
  input logic              da_busy_i,
  input logic              ad_stop_i,
  input logic              ad_run_i,
  input logic              ctrl_we_i,
  input logic [CTRL_W-1:0] ctrl_wdata_i,
  input logic [STAT_W-1:0] status_o
);
  a_r1_live_fifo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_EMPTY] == fifo_empty_i && status_o[ST_AFULL] == fifo_afull_i);

  a_r2_live_da_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_DA] == da_busy_i && status_o[ST_RUN] == ad_run_i);

  a_r3_lost_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_lost_i) |=> status_o[ST_LOST]);

  a_r4_afull_sets_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fifo_afull_i) |=> status_o[ST_CONV]);

  a_r6_lost_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_LOST] && !(ctrl_we_i && !ctrl_wdata_i[CTL_CLR_LO]) |=> status_o[ST_LOST]);

  a_r6_ovf_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_OVF] && !(ctrl_we_i && !ctrl_wdata_i[CTL_CLR_LO+3]) |=> status_o[ST_OVF]);

  a_r7_lost_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && !ctrl_wdata_i[CTL_CLR_LO] && !data_lost_i |=> !status_o[ST_LOST]);

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_lost_i) && ctrl_we_i && !ctrl_wdata_i[CTL_CLR_LO] |=> status_o[ST_LOST]);

  a_r9_pretrig_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && !ctrl_wdata_i[CTL_PRETRIG] |=> !status_o[ST_TRIG]);

  a_r10_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ad_stop_i) |=> !status_o[ST_TRIG]);
endmodule

bind acq_event_status acq_event_status_chk i_chk (.*);

// File: tb/test_acq_event_status.sv
`timescale 1ns/1ps
module test_acq_event_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_empty = 0, fifo_afull = 0, data_lost = 0, eos = 0;
  logic tmr_final = 0, tmr_clk = 0, da_busy = 0, ext_trig = 0;
  logic ad_stop = 0, ad_run = 0, ctrl_we = 0;
  logic [7:0] ctrl_wdata = 8'hFF;
  logic [7:0] status;

  int n_tests = 0, n_fail = 0;
  logic m_lost = 0, m_eos = 0, m_afl = 0, m_ovf = 0, m_trg = 0, m_en = 0;

  always #5 clk = ~clk;

  acq_event_status i_acq_event_status (
    .clk_i(clk), .rst_ni(rst_n),
    .fifo_empty_i(fifo_empty), .fifo_afull_i(fifo_afull),
    .data_lost_i(data_lost), .eos_i(eos),
    .tmr_final_i(tmr_final), .tmr_clk_i(tmr_clk),
    .da_busy_i(da_busy), .ext_trig_i(ext_trig),
    .ad_stop_i(ad_stop), .ad_run_i(ad_run),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .status_o(status)
  );

  function automatic logic [7:0] expected();
    return {ad_run, m_en & m_trg, da_busy, m_ovf, m_eos | m_afl, m_lost, fifo_afull, fifo_empty};
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] mask);
    logic [7:0] exp = expected();
    n_tests++;
    if ((status & mask) !== (exp & mask)) begin
      n_fail++;
      $display("FAIL %s: status=%02h expected=%02h (mask %02h)", req, status, exp, mask);
    end
  endtask

  // control write; bits 2..5 clear latches on 0, bit 6 pretrigger enable
  task automatic wr(logic [7:0] d);
    ctrl_we = 1; ctrl_wdata = d;
    step();
    ctrl_we = 0; ctrl_wdata = 8'hFF;
    if (!d[2]) m_lost = 0;
    if (!d[3]) m_eos = 0;
    if (!d[4]) m_afl = 0;
    if (!d[5]) m_ovf = 0;
    m_en = d[6];
    if (!m_en) m_trg = 0;
  endtask

  task automatic tmr_tick(logic fin);
    tmr_final = fin; tmr_clk = 1;
    step(); step(); step();
    if (fin) m_ovf = 1;
    tmr_clk = 0;
    step(); step(); step();
    tmr_final = 0;
  endtask

  task automatic set_all();
    data_lost = 1; eos = 1; fifo_afull = 1;
    step();
    m_lost = 1; m_eos = 1; m_afl = 1;
    data_lost = 0; eos = 0; fifo_afull = 0;
    step();
    tmr_tick(1);
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 reset", 8'hFF);
    rst_n = 1;
    step();
    chk("R11 after reset", 8'hFF);

    // R1 R2: live bit sweep
    for (int i = 0; i < 32; i++) begin
      logic old_afl = fifo_afull;
      fifo_empty = i[0]; fifo_afull = i[1]; da_busy = i[2]; ad_run = i[3];
      #1;
      chk("R1 R2 live same cycle", 8'hA3);
      step();
      if (fifo_afull && !old_afl) m_afl = 1;
      chk("R1 R2 R4 live sweep", 8'hFF);
    end
    fifo_empty = 0; fifo_afull = 0; da_busy = 0; ad_run = 0;
    wr(8'h00);
    chk("R7 clear all", 8'hFF);

    // R3: exact latency
    data_lost = 1; #1;
    chk("R3 before edge", 8'hFF);
    step(); m_lost = 1; data_lost = 0;
    chk("R3 lost set", 8'hFF);
    repeat (5) step();
    chk("R6 lost hold", 8'hFF);

    // R4: eos alone, then afull alone, cleared independently
    eos = 1; step(); eos = 0; m_eos = 1;
    chk("R4 eos set", 8'hFF);
    fifo_afull = 1; step(); fifo_afull = 0; m_afl = 1; step();
    chk("R4 afull set", 8'hFF);
    wr(8'h37); // clear eos only
    chk("R4 conv held by afull latch", 8'hFF);
    wr(8'h2F); // clear afull only
    chk("R4 conv clear", 8'hFF);

    // R5: overflow latency and gating
    tmr_final = 1; tmr_clk = 1;
    step(); step();
    chk("R5 ovf not yet", 8'hFF);
    step(); m_ovf = 1;
    chk("R5 ovf set", 8'hFF);
    tmr_clk = 0; repeat (3) step(); tmr_final = 0;
    wr(8'h1F);
    chk("R7 ovf clear", 8'hFF);
    tmr_tick(0);
    chk("R5 ovf no final count", 8'hFF);

    // R6 R7: clear-pattern sweep over bits 2..5
    for (int v = 0; v < 16; v++) begin
      set_all();
      chk("R6 all set", 8'hFF);
      wr(8'hC3 | 8'(v << 2));
      chk("R7 R6 clear pattern", 8'hFF);
    end
    wr(8'h00);

    // R8: set and clear in same cycle, from both prior states
    for (int p = 0; p < 2; p++) begin
      if (p == 1) begin data_lost = 1; step(); data_lost = 0; m_lost = 1; step(); end
      data_lost = 1; ctrl_we = 1; ctrl_wdata = 8'h00;
      step();
      ctrl_we = 0; ctrl_wdata = 8'hFF; data_lost = 0;
      m_lost = 1; m_eos = 0; m_afl = 0; m_ovf = 0; m_en = 0;
      chk("R8 set wins", 8'hFF);
      wr(8'h00);
    end

    // R9: trigger ignored while disabled
    ext_trig = 1; repeat (4) step(); ext_trig = 0; step();
    chk("R9 trig disabled", 8'hFF);
    wr(8'h7C);
    chk("R9 enable without trigger", 8'hFF);

    // R10: trigger latency, hold, stop
    ext_trig = 1; step(); step();
    chk("R10 trig not yet", 8'hFF);
    step(); m_trg = 1;
    chk("R10 trig set", 8'hFF);
    ext_trig = 0; repeat (6) step();
    chk("R10 trig hold", 8'hFF);
    ad_stop = 1; step(); ad_stop = 0; m_trg = 0;
    chk("R10 stop clears", 8'hFF);

    // R9: disable discards flag
    ext_trig = 1; repeat (3) step(); ext_trig = 0; m_trg = 1;
    chk("R10 retrigger", 8'hFF);
    wr(8'h3C);
    chk("R9 disable forces 0", 8'hFF);
    wr(8'h7C);
    chk("R9 flag discarded", 8'hFF);

    // R10: stop coincident with synchronized trigger
    ext_trig = 1; step(); step();
    ad_stop = 1; step(); ad_stop = 0;
    chk("R10 stop wins", 8'hFF);
    step(); ext_trig = 0; step();
    chk("R10 stays clear", 8'hFF);

    // R11: reset mid-run clears everything
    set_all();
    ext_trig = 1; repeat (3) step(); ext_trig = 0; m_trg = 1;
    chk("R10 set before reset", 8'hFF);
    rst_n = 0; #1;
    m_lost = 0; m_eos = 0; m_afl = 0; m_ovf = 0; m_trg = 0; m_en = 0;
    chk("R11 async reset", 8'hFF);
    step(); rst_n = 1; step();
    chk("R11 after second reset", 8'hFF);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule